// File: doc/BRIEF.md
# Warp memory access coalescer

This block sits between a SIMD execution unit and the data cache. It accepts one load from a whole warp: one byte address for every lane, a mask that says which lanes take part, and an element width. It sorts the active lanes by the 128-byte line that each address falls into and issues one line request for each distinct line. A scattered warp therefore costs as many requests as it touches lines, and a well-formed warp costs the minimum.

Each request carries the line number and a bit vector of the lanes it serves. That vector is kept in a small in-order queue. When a line comes back, every lane in the vector picks its own element out of the 128 bytes at its own byte offset, in whatever order the lanes address the line. When the last line has returned, the block presents all lane results in one cycle. With them it reports the request count, a per-lane misalignment flag and a flag that says whether the warp reached the ideal request count.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, in_ready is 1 and both req_valid and done_valid are 0.
- R2: A warp produces exactly one request for each distinct 128-byte line touched by an active lane. req_line is the lane address with its low 7 bits dropped. req_lanes holds every active lane whose address falls in that line.
- R3: Lanes whose in_mask bit is 0 never appear in req_lanes and do not cause requests. Their done_data element is zero.
- R4: Requests are issued in ascending order of the lowest lane index that touches each line.
- R5: While req_valid is 1 and req_ready is 0, the request stays asserted and req_line and req_lanes do not change.
- R6: Returned lines are matched to requests in issue order. Each served lane receives the bytes that start at byte offset addr[6:0] of the line, in ascending byte order and little-endian within the element, zero-extended to 128 bits.
- R7: in_size encodes the element width: 0 is 4 bytes, 1 is 8 bytes, 2 or 3 is 16 bytes.
- R8: A lane whose offset plus element width exceeds 128 is flagged in done_misaligned. It is not split into two requests, and its bytes past the end of the line read as zero.
- R9: done_valid pulses for one cycle after the final return has been written. done_reqs gives the number of requests issued. done_coalesced is 1 exactly when that number equals ceil(32 × element bytes / 128).
- R10: A warp with an all-zero mask issues no request and still completes, with done_reqs 0 and done_coalesced 0.
- R11: A line return accepted in the same cycle as a new request handshake is delivered correctly, and the new request is kept for a later return.
- R12: in_ready is 0 from the cycle after a warp is accepted until that warp completes. in_valid is ignored during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Warp load present |
| in_ready | output | 1 | Block can take a warp |
| in_addr | input | 32×32 | Lane byte addresses, lane i at bits [32i+31:32i] |
| in_mask | input | 32 | Active lanes |
| in_size | input | 2 | Element width code |
| req_valid | output | 1 | Line request valid |
| req_ready | input | 1 | Line request accepted |
| req_line | output | 25 | Line number (address bits 31:7) |
| req_lanes | output | 32 | Lanes served by this request |
| ret_valid | input | 1 | Returned line present |
| ret_data | input | 1024 | Returned line, byte b at bits [8b+7:8b] |
| done_valid | output | 1 | One-cycle warp completion |
| done_data | output | 32×128 | Lane results, lane i at bits [128i+127:128i] |
| done_misaligned | output | 32 | Lanes whose element crosses the line end |
| done_reqs | output | 6 | Requests issued for the warp |
| done_coalesced | output | 1 | Request count equals the ideal count |

## Verification
Two things can happen in the same cycle: a new line request handshake, and the return of an earlier line. In that cycle the tag queue is pushed and popped at once while the pending-lane set shrinks. The responder model accepts requests on a repeating ready pattern and returns queued lines on an independent pattern. Scattered warps therefore produce many cycles in which both events fall on one clock edge. The scoreboard judges these cycles by the request order and lane masks it sees, and by the per-lane data delivered at completion.

// File: rtl/coal_pkg.sv
package coal_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } coal_state_e;

  localparam int ELEM_W_MAX = 128;

  // element byte count from the width code; codes 2 and 3 both mean 16 bytes
  function automatic logic [4:0] width_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd4;
      2'd1:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/coal_line_pick.sv
module coal_line_pick #(
  parameter int LANES   = 32,
  parameter int LINE_AW = 25
) (
  input  logic [LANES-1:0]         pending,
  input  logic [LANES*LINE_AW-1:0] lines,
  output logic                     any,
  output logic [LINE_AW-1:0]       pick_line,
  output logic [LANES-1:0]         pick_lanes
);

  // lowest pending lane decides which line goes next
  always_comb begin
    any       = 1'b0;
    pick_line = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pending[i]) begin
        any       = 1'b1;
        pick_line = lines[i*LINE_AW +: LINE_AW];
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_match
    assign pick_lanes[g] = pending[g] && (lines[g*LINE_AW +: LINE_AW] == pick_line);
  end

endmodule

// File: rtl/coal_tag_fifo.sv
module coal_tag_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [$clog2(DEPTH+1)-1:0] count
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  assign dout = mem[rptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/coal_lane_extract.sv
module coal_lane_extract
  import coal_pkg::*;
#(
  parameter int LINE_BYTES = 128,
  parameter int OFF_W      = 7
) (
  input  logic [LINE_BYTES*8-1:0] line,
  input  logic [OFF_W-1:0]        off,
  input  logic [1:0]              size,
  output logic [ELEM_W_MAX-1:0]   elem,
  output logic                    mis
);

  logic [LINE_BYTES*8-1:0] shifted;
  logic [4:0]              nbytes;

  assign nbytes  = width_bytes(size);
  assign shifted = line >> {off, 3'b000};
  assign mis     = (int'(off) + int'(nbytes)) > LINE_BYTES;

  always_comb begin
    elem = '0;
    case (nbytes)
      5'd4:    elem[31:0] = shifted[31:0];
      5'd8:    elem[63:0] = shifted[63:0];
      default: elem       = shifted[ELEM_W_MAX-1:0];
    endcase
  end

endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import coal_pkg::*;
#(
  parameter int LANES      = 32,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_AW   = ADDR_W - OFF_W,
  localparam int CNT_W     = $clog2(LANES+1),
  localparam int ELEM_W    = ELEM_W_MAX
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]        in_mask,
  input  logic [1:0]              in_size,
  output logic                    req_valid,
  input  logic                    req_ready,
  output logic [LINE_AW-1:0]      req_line,
  output logic [LANES-1:0]        req_lanes,
  input  logic                    ret_valid,
  input  logic [LINE_BYTES*8-1:0] ret_data,
  output logic                    done_valid,
  output logic [LANES*ELEM_W-1:0] done_data,
  output logic [LANES-1:0]        done_misaligned,
  output logic [CNT_W-1:0]        done_reqs,
  output logic                    done_coalesced
);

  localparam int IDEAL_4  = (LANES*4  + LINE_BYTES - 1) / LINE_BYTES;
  localparam int IDEAL_8  = (LANES*8  + LINE_BYTES - 1) / LINE_BYTES;
  localparam int IDEAL_16 = (LANES*16 + LINE_BYTES - 1) / LINE_BYTES;

  coal_state_e             state_q;
  logic [LANES*ADDR_W-1:0] addr_q;
  logic [LANES-1:0]        mask_q;
  logic [LANES-1:0]        pending_q;
  logic [1:0]              size_q;
  logic [CNT_W-1:0]        nreq_q;
  logic [ELEM_W-1:0]       lane_data_q [LANES];

  logic [LANES*LINE_AW-1:0] lane_lines;
  logic                     any_pend;
  logic [LINE_AW-1:0]       pick_line;
  logic [LANES-1:0]         pick_lanes;
  logic                     issue, ret_take;
  logic [LANES-1:0]         ret_lanes;
  logic [CNT_W-1:0]         tag_cnt;
  logic [ELEM_W-1:0]        lane_elem [LANES];
  logic [LANES-1:0]         lane_mis;
  logic [CNT_W-1:0]         ideal;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_lines[g*LINE_AW +: LINE_AW] = addr_q[g*ADDR_W+OFF_W +: LINE_AW];

    coal_lane_extract #(
      .LINE_BYTES(LINE_BYTES),
      .OFF_W     (OFF_W)
    ) u_ext (
      .line(ret_data),
      .off (addr_q[g*ADDR_W +: OFF_W]),
      .size(size_q),
      .elem(lane_elem[g]),
      .mis (lane_mis[g])
    );

    assign done_data[g*ELEM_W +: ELEM_W] = lane_data_q[g];
  end

  coal_line_pick #(
    .LANES  (LANES),
    .LINE_AW(LINE_AW)
  ) u_pick (
    .pending   (pending_q),
    .lines     (lane_lines),
    .any       (any_pend),
    .pick_line (pick_line),
    .pick_lanes(pick_lanes)
  );

  assign in_ready  = (state_q == ST_IDLE);
  assign req_valid = (state_q == ST_BUSY) && any_pend;
  assign req_line  = pick_line;
  assign req_lanes = pick_lanes;
  assign issue     = req_valid && req_ready;
  assign ret_take  = ret_valid && (state_q == ST_BUSY) && (tag_cnt != '0);

  coal_tag_fifo #(
    .WIDTH(LANES),
    .DEPTH(LANES)
  ) u_tags (
    .clk  (clk),
    .rst  (rst),
    .push (issue),
    .din  (pick_lanes),
    .pop  (ret_take),
    .dout (ret_lanes),
    .count(tag_cnt)
  );

  always_comb begin
    case (width_bytes(size_q))
      5'd4:    ideal = CNT_W'(IDEAL_4);
      5'd8:    ideal = CNT_W'(IDEAL_8);
      default: ideal = CNT_W'(IDEAL_16);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q         <= ST_IDLE;
      addr_q          <= '0;
      mask_q          <= '0;
      pending_q       <= '0;
      size_q          <= '0;
      nreq_q          <= '0;
      done_valid      <= 1'b0;
      done_misaligned <= '0;
      done_reqs       <= '0;
      done_coalesced  <= 1'b0;
      for (int i = 0; i < LANES; i++) lane_data_q[i] <= '0;
    end else begin
      done_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (in_valid) begin
            addr_q    <= in_addr;
            mask_q    <= in_mask;
            pending_q <= in_mask;
            size_q    <= in_size;
            nreq_q    <= '0;
            state_q   <= ST_BUSY;
            for (int i = 0; i < LANES; i++) lane_data_q[i] <= '0;
          end
        end
        default: begin
          if (issue) begin
            pending_q <= pending_q & ~pick_lanes;
            nreq_q    <= nreq_q + CNT_W'(1);
          end
          if (ret_take) begin
            for (int i = 0; i < LANES; i++) begin
              if (ret_lanes[i]) lane_data_q[i] <= lane_elem[i];
            end
          end
          if (!any_pend && (tag_cnt == '0)) begin
            state_q         <= ST_IDLE;
            done_valid      <= 1'b1;
            done_reqs       <= nreq_q;
            done_coalesced  <= (nreq_q == ideal);
            done_misaligned <= lane_mis & mask_q;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
  parameter int LANES   = 32,
  parameter int LINE_AW = 25
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_ready,
  input logic               req_valid,
  input logic               req_ready,
  input logic [LINE_AW-1:0] req_line,
  input logic [LANES-1:0]   req_lanes,
  input logic               done_valid,
  input logic [LANES-1:0]   mask_q,
  input logic [LANES-1:0]   pending_q
);

  logic [LANES-1:0] lowest_pend;
  assign lowest_pend = pending_q & (~pending_q + 1'b1);

  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (in_ready && !req_valid && !done_valid));

  a_r2_req_nonempty: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_lanes != '0));

  a_r3_req_in_mask: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> ((req_lanes & ~mask_q) == '0));

  a_r4_lowest_lane: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> ((req_lanes & lowest_pend) != '0));

  a_r5_req_hold: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_line) && $stable(req_lanes)));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid);

  a_r12_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

endmodule

bind warp_coalescer coal_checker #(
  .LANES  (LANES),
  .LINE_AW(LINE_AW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_line  (req_line),
  .req_lanes (req_lanes),
  .done_valid(done_valid),
  .mask_q    (mask_q),
  .pending_q (pending_q)
);

// File: tb/tb_warp_coalescer.sv
module tb_warp_coalescer;

  localparam int L  = 32;
  localparam int LB = 128;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [L*32-1:0] in_addr = '0;
  logic [L-1:0]   in_mask = '0;
  logic [1:0]     in_size = '0;
  logic           req_valid;
  logic           req_ready = 1'b0;
  logic [24:0]    req_line;
  logic [L-1:0]   req_lanes;
  logic           ret_valid = 1'b0;
  logic [LB*8-1:0] ret_data = '0;
  logic           done_valid;
  logic [L*128-1:0] done_data;
  logic [L-1:0]   done_misaligned;
  logic [5:0]     done_reqs;
  logic           done_coalesced;

  warp_coalescer dut (.*);

  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0, n_done = 0, cyc = 0;
  bit finished = 0;

  logic [24:0]    exp_line_q [$];
  logic [L-1:0]   exp_lanes_q [$];
  logic [24:0]    ret_q [$];
  logic [L*128-1:0] exp_data_q [$];
  logic [L-1:0]   exp_mis_q [$];
  int             exp_cnt_q [$];
  bit             exp_coal_q [$];
  logic [31:0]    av [L];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mb(input logic [31:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ (a[23:16] * 8'd3) ^ 8'h5A;
  endfunction

  function automatic logic [LB*8-1:0] build_line(input logic [24:0] ln);
    logic [LB*8-1:0] d;
    for (int b = 0; b < LB; b++) d[b*8 +: 8] = mb({ln, 7'b0} + 32'(b));
    return d;
  endfunction

  // driver: computes the expected requests and results, then applies the warp
  task automatic run_warp(input logic [L-1:0] mask, input logic [1:0] size, input bit hold);
    logic [L-1:0] pend, lanes;
    logic [L*128-1:0] d;
    logic [L-1:0] mis;
    logic [24:0] ln;
    int nreq, nb, off, lo, prev;
    nb = (size == 2'd0) ? 4 : (size == 2'd1) ? 8 : 16;
    pend = mask; nreq = 0;
    while (pend != '0) begin
      lo = 0;
      for (int i = L - 1; i >= 0; i--) if (pend[i]) lo = i;
      ln = av[lo][31:7];
      lanes = '0;
      for (int i = 0; i < L; i++) if (pend[i] && av[i][31:7] == ln) lanes[i] = 1'b1;
      exp_line_q.push_back(ln);
      exp_lanes_q.push_back(lanes);
      pend &= ~lanes;
      nreq++;
    end
    d = '0; mis = '0;
    for (int i = 0; i < L; i++) begin
      if (mask[i]) begin
        off = int'(av[i][6:0]);
        if (off + nb > LB) mis[i] = 1'b1;
        for (int b = 0; b < nb; b++)
          if (off + b < LB) d[i*128 + b*8 +: 8] = mb(av[i] + 32'(b));
      end
    end
    exp_data_q.push_back(d);
    exp_mis_q.push_back(mis);
    exp_cnt_q.push_back(nreq);
    exp_coal_q.push_back(nreq == (L * nb + LB - 1) / LB);

    @(negedge clk);
    while (!in_ready) @(negedge clk);
    for (int i = 0; i < L; i++) in_addr[i*32 +: 32] = av[i];
    in_mask = mask; in_size = size; in_valid = 1'b1;
    prev = n_done;
    @(negedge clk);
    chk(in_ready == 1'b0, "R12", "in_ready after accept", 128'(in_ready), 128'(0));
    if (hold) begin
      // R12: garbage offered while busy must be ignored
      in_addr = '1; in_mask = '1; in_size = 2'd0;
      @(negedge clk);
      chk(in_ready == 1'b0, "R12", "in_ready while busy", 128'(in_ready), 128'(0));
    end
    in_valid = 1'b0;
    while (n_done == prev) @(negedge clk);
  endtask

  // responder and request monitor
  bit prev_stall = 0;
  logic [24:0] prev_line;
  logic [L-1:0] prev_lanes;
  always @(negedge clk) begin
    bit rdy;
    cyc++;
    if (!rst) begin
      if (prev_stall) begin
        chk(req_valid && req_line == prev_line && req_lanes == prev_lanes, "R5",
            "stalled request held", {req_valid, req_line, req_lanes}, {1'b1, prev_line, prev_lanes});
      end
      // returns first: only lines handed over at an earlier edge
      if (ret_q.size() > 0 && (cyc % 4) != 2) begin
        ret_valid = 1'b1;
        ret_data  = build_line(ret_q.pop_front());
      end else begin
        ret_valid = 1'b0;
      end
      rdy = (cyc % 3) != 1;
      req_ready = rdy;
      if (req_valid && rdy) begin
        if (exp_line_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected request", 128'(req_line), 128'(0));
        end else begin
          logic [24:0] el;
          logic [L-1:0] em;
          el = exp_line_q.pop_front();
          em = exp_lanes_q.pop_front();
          chk(req_line == el, "R4", "request line order", 128'(req_line), 128'(el));
          chk(req_lanes == em, "R2", "request lane set", 128'(req_lanes), 128'(em));
        end
        ret_q.push_back(req_line);
      end
      prev_stall = req_valid && !rdy;
      prev_line  = req_line;
      prev_lanes = req_lanes;
    end
  end

  // completion monitor
  always @(negedge clk) begin
    if (!rst && done_valid) begin
      if (exp_cnt_q.size() == 0) begin
        chk(1'b0, "R9", "unexpected completion", 128'(1), 128'(0));
      end else begin
        logic [L*128-1:0] ed;
        logic [L-1:0] em;
        int ec;
        bit eco;
        ed = exp_data_q.pop_front(); em = exp_mis_q.pop_front();
        ec = exp_cnt_q.pop_front(); eco = exp_coal_q.pop_front();
        for (int i = 0; i < L; i++)
          chk(done_data[i*128 +: 128] == ed[i*128 +: 128], "R6",
              $sformatf("lane %0d data (R3 for inactive)", i), done_data[i*128 +: 128], ed[i*128 +: 128]);
        chk(done_misaligned == em, "R8", "misaligned flags", 128'(done_misaligned), 128'(em));
        chk(int'(done_reqs) == ec, "R9", "request count", 128'(done_reqs), 128'(ec));
        chk(done_coalesced == eco, "R9", "coalesced flag", 128'(done_coalesced), 128'(eco));
      end
      n_done++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", 128'(in_ready), 128'(1));
    chk(req_valid == 1'b0, "R1", "req_valid after reset", 128'(req_valid), 128'(0));
    chk(done_valid == 1'b0, "R1", "done_valid after reset", 128'(done_valid), 128'(0));

    // R2/R9: unit-stride 4-byte, aligned -> one request, coalesced
    for (int i = 0; i < L; i++) av[i] = 32'h0000_1000 + 32'(4 * i);
    run_warp('1, 2'd0, 1'b0);
    // R7: unit-stride 8-byte -> two requests
    for (int i = 0; i < L; i++) av[i] = 32'h0002_0100 + 32'(8 * i);
    run_warp('1, 2'd1, 1'b0);
    // R7: unit-stride 16-byte -> four requests
    for (int i = 0; i < L; i++) av[i] = 32'h0003_0000 + 32'(16 * i);
    run_warp('1, 2'd2, 1'b0);
    // R7: code 3 acts as 16 bytes
    for (int i = 0; i < L; i++) av[i] = 32'h0008_0000 + 32'(16 * i);
    run_warp('1, 2'd3, 1'b0);
    // R4/R11/R12: reverse scatter, one line per lane, many overlapping issue/return cycles
    for (int i = 0; i < L; i++) av[i] = 32'h0010_0000 + 32'((L - 1 - i) * 256) + 32'(4 * i);
    run_warp('1, 2'd0, 1'b1);
    // R6: permuted order inside one line
    for (int i = 0; i < L; i++) av[i] = 32'h0005_0080 + 32'(((i * 5) % L) * 4);
    run_warp('1, 2'd0, 1'b0);
    // R3: partial mask, unaligned 8-byte base
    for (int i = 0; i < L; i++) av[i] = 32'h0000_6008 + 32'(8 * i);
    run_warp(32'hF0F0_0F0F, 2'd1, 1'b0);
    // R8: elements crossing the line end
    for (int i = 0; i < L; i++) av[i] = 32'h0000_7000 + 32'(132 * i);
    run_warp('1, 2'd1, 1'b0);
    // R8: 16-byte elements at offset 120
    for (int i = 0; i < L; i++) av[i] = 32'h0000_9078 + 32'(256 * (i % 3));
    run_warp(32'h0000_FFFF, 2'd2, 1'b0);
    // R9: all lanes one address with 16 bytes -> one request, not the ideal count
    for (int i = 0; i < L; i++) av[i] = 32'h000A_0040;
    run_warp('1, 2'd2, 1'b0);
    // R10: empty mask
    for (int i = 0; i < L; i++) av[i] = 32'h000B_0000 + 32'(4 * i);
    run_warp('0, 2'd0, 1'b0);

    repeat (5) @(negedge clk);
    chk(exp_line_q.size() == 0, "R2", "requests left unissued", 128'(exp_line_q.size()), 128'(0));
    chk(exp_cnt_q.size() == 0, "R9", "completions missing", 128'(exp_cnt_q.size()), 128'(0));
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule